// File: doc/BRIEF.md
# Current-Dependent Phase Compensation Selector

This block chooses one of three programmable phase-correction angles for a single metering phase. The choice depends on where the measured RMS current lies relative to two current thresholds. A current sensor whose phase error drifts with load can therefore be corrected by a three-step approximation. The same strobe also produces the apparent-power product, which is the raw RMS voltage multiplied by the raw RMS current.

The thresholds and angles are loaded through a small register-write port. Each input strobe carries one RMS voltage/current pair. One clock later the block presents the chosen angle and the product, together with a single-cycle valid pulse. When both thresholds are programmed to zero, the first angle is used for every current, which gives constant compensation.

Top module: `phase_comp_sel`

## Requirements
- R1: While reset is asserted and after it is released, both valid outputs are low and the angle and product outputs are zero. All five configuration registers reset to zero.
- R2: The register map is: address 0 = upper current threshold, address 1 = lower current threshold, address 2 = high-current angle, address 3 = mid-current angle, address 4 = low-current angle. When the current is strictly greater than the upper threshold, the high-current angle is output.
- R3: When the current does not exceed the upper threshold and is strictly less than the lower threshold, the low-current angle is output.
- R4: When the current lies between the thresholds, the mid-current angle is output. This includes a current exactly equal to either threshold.
- R5: When both thresholds are zero, the high-current angle is output for every current, including zero.
- R6: The apparent-power output is the 48-bit unsigned product of the 24-bit unsigned RMS voltage and the 24-bit unsigned RMS current, without truncation.
- R7: Both valid outputs rise exactly one clock after each input strobe and stay high for one clock per strobe. Back-to-back strobes give back-to-back results.
- R8: On cycles without a strobe, the angle and product outputs hold their last values, whatever the RMS inputs do.
- R9: A register write in the same cycle as a strobe does not affect that strobe's result. It takes effect from the next strobe.
- R10: Writes to addresses 5 to 7 change nothing. An angle write keeps only the low 16 bits of the write data as a signed angle.
- R11: If the lower threshold exceeds the upper one, the upper-threshold test takes priority: a current above the upper threshold selects the high-current angle, even when it is also below the lower threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | 24 | Register write data |
| in_valid | input | 1 | Strobe marking a valid RMS pair |
| rms_v | input | 24 | Raw RMS voltage, unsigned |
| rms_i | input | 24 | Raw RMS current, unsigned |
| ang_valid | output | 1 | Angle result valid pulse |
| ang_out | output | 16 | Selected compensation angle, signed |
| app_valid | output | 1 | Product result valid pulse |
| app_pwr | output | 48 | Apparent-power product, unsigned |

## Verification
A corrupted threshold or angle register cannot be seen until a strobe needs it. It then shows as a wrong angle on the clock after that strobe, and it keeps showing on every later strobe in the affected segment until the register is rewritten. A wrong segment decision or a broken product appears on the first clock after the strobe whose current crosses the faulty boundary. A valid flag or a hold register that is out of step shows in the very next cycle. For this reason the reference model compares all outputs on every clock, including idle ones.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [1:0] {
        SEG_HIGH = 2'd0,
        SEG_MID  = 2'd1,
        SEG_LOW  = 2'd2
    } seg_e;

    localparam int unsigned NUM_ANG      = 3;
    localparam int unsigned ADR_THR_HI   = 0;
    localparam int unsigned ADR_THR_LO   = 1;
    localparam int unsigned ADR_ANG_BASE = 2;
endpackage

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs
    import pcs_pkg::*;
#(
    parameter int unsigned CUR_W  = 24,
    parameter int unsigned ANG_W  = 16,
    parameter int unsigned DATA_W = 24,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [CUR_W-1:0]                thr_hi,
    output logic [CUR_W-1:0]                thr_lo,
    output logic [NUM_ANG-1:0][ANG_W-1:0]   ang,
    output logic                            const_mode
);
    localparam int unsigned NUM_REGS = ADR_ANG_BASE + NUM_ANG;

    typedef struct packed {
        logic [CUR_W-1:0]              thr_hi;
        logic [CUR_W-1:0]              thr_lo;
        logic [NUM_ANG-1:0][ANG_W-1:0] ang;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic               hit_hi;
    logic               hit_lo;
    logic [NUM_ANG-1:0] hit_ang;
    logic               hit_none;

    assign hit_hi = we && (addr == ADDR_W'(ADR_THR_HI));
    assign hit_lo = we && (addr == ADDR_W'(ADR_THR_LO));

    for (genvar g = 0; g < NUM_ANG; g++) begin : g_ang_dec
        assign hit_ang[g] = we && (addr == ADDR_W'(ADR_ANG_BASE + g));
    end

    assign hit_none = we && (32'(addr) >= NUM_REGS);

    always_comb begin
        cfg_d = cfg_q;
        if (hit_hi) begin
            cfg_d.thr_hi = CUR_W'(wdata);
        end
        if (hit_lo) begin
            cfg_d.thr_lo = CUR_W'(wdata);
        end
        for (int k = 0; k < NUM_ANG; k++) begin
            if (hit_ang[k]) begin
                cfg_d.ang[k] = ANG_W'(wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign thr_hi     = cfg_q.thr_hi;
    assign thr_lo     = cfg_q.thr_lo;
    assign ang        = cfg_q.ang;
    assign const_mode = (cfg_q.thr_hi == '0) && (cfg_q.thr_lo == '0);

    // R10
    unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_none |=> $stable(thr_hi) && $stable(thr_lo) && $stable(ang));

endmodule

// File: rtl/pcs_seg_pick.sv
module pcs_seg_pick
    import pcs_pkg::*;
#(
    parameter int unsigned CUR_W = 24
) (
    input  logic [CUR_W-1:0]   cur,
    input  logic [CUR_W-1:0]   thr_hi,
    input  logic [CUR_W-1:0]   thr_lo,
    input  logic               const_mode,
    output logic [NUM_ANG-1:0] sel
);
    seg_e seg;

    always_comb begin
        if (const_mode || (cur > thr_hi)) begin
            seg = SEG_HIGH;
        end else if (cur < thr_lo) begin
            seg = SEG_LOW;
        end else begin
            seg = SEG_MID;
        end
    end

    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_ANG; k++) begin
            if (int'(seg) == k) begin
                sel[k] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcs_out_stage.sv
module pcs_out_stage
    import pcs_pkg::*;
#(
    parameter int unsigned VOLT_W = 24,
    parameter int unsigned CUR_W  = 24,
    parameter int unsigned ANG_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [VOLT_W-1:0]             rms_v,
    input  logic [CUR_W-1:0]              rms_i,
    input  logic [NUM_ANG-1:0]            sel,
    input  logic [NUM_ANG-1:0][ANG_W-1:0] ang,
    output logic                          out_valid,
    output logic [ANG_W-1:0]              ang_res,
    output logic [VOLT_W+CUR_W-1:0]       app_res
);
    localparam int unsigned PROD_W = VOLT_W + CUR_W;

    typedef struct packed {
        logic              vld;
        logic [ANG_W-1:0]  ang;
        logic [PROD_W-1:0] app;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = in_valid;
        if (in_valid) begin
            out_d.app = PROD_W'(rms_v) * PROD_W'(rms_i);
            out_d.ang = '0;
            for (int k = 0; k < NUM_ANG; k++) begin
                if (sel[k]) begin
                    out_d.ang = out_d.ang | ang[k];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign ang_res   = out_q.ang;
    assign app_res   = out_q.app;

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ang_res) && $stable(app_res));

    // R6
    product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> app_res == (PROD_W'($past(rms_v)) * PROD_W'($past(rms_i))));

endmodule

// File: rtl/phase_comp_sel.sv
module phase_comp_sel
    import pcs_pkg::*;
#(
    parameter int unsigned VOLT_W = 24,
    parameter int unsigned CUR_W  = 24,
    parameter int unsigned ANG_W  = 16,
    parameter int unsigned DATA_W = 24,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    input  logic                     in_valid,
    input  logic [VOLT_W-1:0]        rms_v,
    input  logic [CUR_W-1:0]         rms_i,
    output logic                     ang_valid,
    output logic signed [ANG_W-1:0]  ang_out,
    output logic                     app_valid,
    output logic [VOLT_W+CUR_W-1:0]  app_pwr
);
    logic [CUR_W-1:0]              thr_hi;
    logic [CUR_W-1:0]              thr_lo;
    logic [NUM_ANG-1:0][ANG_W-1:0] ang_bank;
    logic                          const_mode;
    logic [NUM_ANG-1:0]            sel;
    logic                          res_valid;
    logic [ANG_W-1:0]              ang_res;

    pcs_cfg_regs #(
        .CUR_W (CUR_W),
        .ANG_W (ANG_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo),
        .ang       (ang_bank),
        .const_mode(const_mode)
    );

    pcs_seg_pick #(
        .CUR_W(CUR_W)
    ) pick_i (
        .cur       (rms_i),
        .thr_hi    (thr_hi),
        .thr_lo    (thr_lo),
        .const_mode(const_mode),
        .sel       (sel)
    );

    pcs_out_stage #(
        .VOLT_W(VOLT_W),
        .CUR_W (CUR_W),
        .ANG_W (ANG_W)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .rms_v    (rms_v),
        .rms_i    (rms_i),
        .sel      (sel),
        .ang      (ang_bank),
        .out_valid(res_valid),
        .ang_res  (ang_res),
        .app_res  (app_pwr)
    );

    assign ang_valid = res_valid;
    assign app_valid = res_valid;
    assign ang_out   = $signed(ang_res);

    // R5
    const_angle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && const_mode |=> ang_res == $past(ang_bank[0]));

    // R2
    high_angle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (rms_i > thr_hi) |=> ang_res == $past(ang_bank[0]));

    // R4
    mid_angle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !const_mode && (rms_i <= thr_hi) && (rms_i >= thr_lo)
        |=> ang_res == $past(ang_bank[1]));

endmodule

// File: tb/phase_comp_sel_tb_top.sv
module phase_comp_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [23:0] cfg_wdata;
    logic        in_valid;
    logic [23:0] rms_v;
    logic [23:0] rms_i;
    logic        ang_valid;
    logic signed [15:0] ang_out;
    logic        app_valid;
    logic [47:0] app_pwr;

    int    n_cmp  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    logic [23:0] m_hi = '0;
    logic [23:0] m_lo = '0;
    logic [15:0] m_ang [3] = '{16'h0, 16'h0, 16'h0};

    logic        e_vld = 1'b0;
    logic [15:0] e_ang = '0;
    logic [47:0] e_app = '0;

    always #10 clk = ~clk;

    phase_comp_sel dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .in_valid (in_valid),
        .rms_v    (rms_v),
        .rms_i    (rms_i),
        .ang_valid(ang_valid),
        .ang_out  (ang_out),
        .app_valid(app_valid),
        .app_pwr  (app_pwr)
    );

    function automatic logic [15:0] ref_angle(input logic [23:0] cur);
        if (m_hi == 0 && m_lo == 0) return m_ang[0];
        if (cur > m_hi) return m_ang[0];
        if (cur < m_lo) return m_ang[2];
        return m_ang[1];
    endfunction

    task automatic check1(input string what, input logic [47:0] got, input logic [47:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        check1("ang_valid", 48'(ang_valid), 48'(e_vld));
        check1("app_valid", 48'(app_valid), 48'(e_vld));
        check1("ang_out",   48'($unsigned(ang_out)), 48'(e_ang));
        check1("app_pwr",   app_pwr, e_app);
    endtask

    task automatic cyc(input bit we, input int addr, input logic [23:0] wd,
                       input bit iv, input logic [23:0] v, input logic [23:0] i);
        cfg_we    = we;
        cfg_addr  = 3'(addr);
        cfg_wdata = wd;
        in_valid  = iv;
        rms_v     = v;
        rms_i     = i;
        e_vld = iv;
        if (iv) begin
            e_ang = ref_angle(i);
            e_app = 48'(v) * 48'(i);
        end
        if (we) begin
            case (addr)
                0: m_hi = wd;
                1: m_lo = wd;
                2, 3, 4: m_ang[addr-2] = wd[15:0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int addr, input logic [23:0] wd);
        cyc(1'b1, addr, wd, 1'b0, 24'h00_0BAD, 24'h00_0DEF);
    endtask

    task automatic strobe(input logic [23:0] v, input logic [23:0] i);
        cyc(1'b0, 0, 24'h0, 1'b1, v, i);
    endtask

    task automatic idle(input logic [23:0] v, input logic [23:0] i);
        cyc(1'b0, 0, 24'h0, 1'b0, v, i);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; rms_v = '0; rms_i = '0;
        @(negedge clk);
        // R1: outputs held at zero during reset, even with a strobe
        tag = "R1";
        for (int k = 0; k < 3; k++) begin
            cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 24'h00_7777;
            in_valid = 1'b1; rms_v = 24'd5; rms_i = 24'd9;
            @(posedge clk); @(negedge clk);
            compare_all();
        end
        cfg_we = 1'b0; in_valid = 1'b0;
        rst_n = 1'b1;
        idle(24'd1, 24'd1);
        // R1: registers came out of reset as zero -> zero angle
        strobe(24'd3, 24'd4);

        // R5: zero thresholds give constant high-current angle
        tag = "R5";
        wr(2, 24'h00_1234);
        wr(3, 24'h00_5678);
        wr(4, 24'h00_9ABC);
        strobe(24'd10, 24'd0);
        strobe(24'd10, 24'd1);
        strobe(24'd10, 24'hFF_FFFF);

        // R2, R3, R4: three-segment selection
        wr(0, 24'd1000);
        wr(1, 24'd100);
        tag = "R2"; strobe(24'd7, 24'd1001);
        tag = "R2"; strobe(24'd7, 24'hFF_FFFF);
        tag = "R3"; strobe(24'd7, 24'd99);
        tag = "R3"; strobe(24'd7, 24'd0);
        tag = "R4"; strobe(24'd7, 24'd500);
        tag = "R4"; strobe(24'd7, 24'd1000);
        tag = "R4"; strobe(24'd7, 24'd100);

        // R6: product corners
        tag = "R6";
        strobe(24'hFF_FFFF, 24'hFF_FFFF);
        strobe(24'h12_3456, 24'h00_0002);
        strobe(24'd0, 24'h80_0000);

        // R7: back-to-back and gapped strobes
        tag = "R7";
        strobe(24'd11, 24'd2000);
        strobe(24'd12, 24'd50);
        strobe(24'd13, 24'd300);
        idle(24'd0, 24'd0);
        strobe(24'd14, 24'd5);

        // R8: inputs wiggle without strobe, outputs hold
        tag = "R8";
        idle(24'hAA_AAAA, 24'd2000);
        idle(24'h55_5555, 24'd1);
        idle(24'h00_0001, 24'd500);

        // R9: write colliding with strobe uses old angle
        tag = "R9";
        cyc(1'b1, 2, 24'h00_4321, 1'b1, 24'd3, 24'd5000);
        strobe(24'd3, 24'd5000);
        cyc(1'b1, 0, 24'd10, 1'b1, 24'd3, 24'd500);
        strobe(24'd3, 24'd500);

        // R10: unused addresses and angle truncation
        tag = "R10";
        wr(5, 24'hFF_FFFF);
        wr(6, 24'h00_0000);
        wr(7, 24'h12_3456);
        strobe(24'd1, 24'd20);
        strobe(24'd1, 24'd5);
        strobe(24'd1, 24'd50);
        wr(4, 24'hAB_CDEF);
        strobe(24'd1, 24'd0);

        // R11: crossed thresholds, upper test wins
        tag = "R11";
        wr(0, 24'd1000);
        wr(1, 24'd2000);
        strobe(24'd2, 24'd1500);
        strobe(24'd2, 24'd500);
        strobe(24'd2, 24'd2500);

        // R5: back to constant mode after nonzero thresholds
        tag = "R5";
        wr(0, 24'd0);
        wr(1, 24'd0);
        strobe(24'd9, 24'd0);
        strobe(24'd9, 24'd777);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule